// File: doc/BRIEF.md
# Management Memory Range Guard

This block holds one base/mask range register pair that fences off the memory used by the processor's system-management handler. A register port lets the handler program the pair. The block takes a flag that says whether the processor is in management mode. Writes made while that flag is low are dropped, and they raise a general-protection fault pulse. A capability output tells software that the range pair exists.

An address lookup port gives three results: whether an address falls in the range, whether the access must be blocked, and which memory type applies. A hit replaces the memory type produced by the general cacheability logic. Outside management mode a hit is forced to uncacheable and marked blocked. Inside management mode a hit takes the type stored in the base register.

The block also owns the base of the 4 KB local interrupt-controller window. When a relocation would place that window inside the protected range, the block refuses it and pulses a separate fault output.

Top module: `mgmt_range_guard`

## Requirements
- R1: After reset the base register reads 0, the mask register reads 0 (range disabled), the interrupt-controller base is 0xFEE00000, and both fault outputs are low.
- R2: `cap_o` has bit 11 set, bits 7:0 equal to the parameter VAR_COUNT (default 10), and every other bit zero.
- R3: A register write with `mgmt_mode_i` high takes effect on the next clock edge. Selector 0 is the base register, which keeps address bits 31:12 and memory type bits 7:0. Selector 1 is the mask register, which keeps mask bits 31:12 and the valid bit 11. All other bits read back as zero.
- R4: A register write with `mgmt_mode_i` low leaves both registers unchanged. `gp_fault_o` is high for exactly the one cycle that follows that write.
- R5: An address hits when the valid bit is set and (address AND mask) equals (base AND mask) over bits 31:12. While the valid bit is clear, nothing hits.
- R6: A hit with `mgmt_mode_i` low drives `blocked_o` high and `eff_type_o` to 0 (uncacheable).
- R7: A hit with `mgmt_mode_i` high drives `eff_type_o` to the base register's type field (6 means write-back) and keeps `blocked_o` low.
- R8: On a miss, `eff_type_o` equals `gen_type_i` and `blocked_o` is low.
- R9: A relocation whose 4 KB window misses the range replaces the interrupt-controller base on the next edge. Bits 11:0 of the written value are dropped.
- R10: A relocation whose window hits the range is refused in either mode. The base keeps its value and `reloc_fault_o` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mgmt_mode_i | input | 1 | Processor is in management mode |
| reg_wr_i | input | 1 | Range register write strobe |
| reg_sel_i | input | 1 | 0 selects base, 1 selects mask |
| reg_wdata_i | input | 32 | Range register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| gp_fault_o | output | 1 | General-protection fault pulse |
| cap_o | output | 32 | Capability word |
| lookup_addr_i | input | 32 | Physical address to classify |
| gen_type_i | input | 8 | Memory type from general cacheability logic |
| hit_o | output | 1 | Address falls in the protected range |
| blocked_o | output | 1 | Access refused |
| eff_type_o | output | 8 | Effective memory type |
| lapic_wr_i | input | 1 | Interrupt-controller base relocation strobe |
| lapic_wdata_i | input | 32 | Proposed interrupt-controller base |
| lapic_base_o | output | 32 | Current interrupt-controller base |
| reloc_fault_o | output | 1 | Refused relocation pulse |

## Verification
The bench attacks the mode gate on writes. A design that honoured a write made outside management mode would let the mask be cleared, and the protected range would open up. Addresses are drawn both just inside and just outside the masked boundary of the range, so a compare that ignored the mask, or an override left active after the valid bit was cleared, shows up as a wrong hit or a wrong type. Relocations are aimed into the range from both modes, which exposes a check that lets management mode through or that updates the base before refusing.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int TYPE_W = 8;
  localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
  localparam logic [TYPE_W-1:0] MT_WB = 8'd6;
  localparam int VALID_BIT = 11;
  localparam int CAP_RANGE_BIT = 11;
  typedef enum logic {SEL_BASE = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/mrg_regs.sv
module mrg_regs
  import mrg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-PAGE_W-1:0] base_pfn_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [ADDR_W-PAGE_W-1:0] mask_pfn_o,
  output logic              valid_o,
  output logic              gp_fault_o,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int PFN_W = ADDR_W - PAGE_W;

  logic [PFN_W-1:0]  base_q, mask_q;
  logic [TYPE_W-1:0] type_q;
  logic              valid_q, fault_q;
  logic              wr_ok;

  assign wr_ok = wr_i && mgmt_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      type_q  <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_i && !mgmt_mode_i;
      if (wr_ok) begin
        if (reg_sel_e'(sel_i) == SEL_BASE) begin
          base_q <= wdata_i[ADDR_W-1:PAGE_W];
          type_q <= wdata_i[TYPE_W-1:0];
        end else begin
          mask_q  <= wdata_i[ADDR_W-1:PAGE_W];
          valid_q <= wdata_i[VALID_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(sel_i) == SEL_BASE) begin
      rdata_o[ADDR_W-1:PAGE_W] = base_q;
      rdata_o[TYPE_W-1:0]      = type_q;
    end else begin
      rdata_o[ADDR_W-1:PAGE_W] = mask_q;
      rdata_o[VALID_BIT]       = valid_q;
    end
  end

  assign base_pfn_o = base_q;
  assign type_o     = type_q;
  assign mask_pfn_o = mask_q;
  assign valid_o    = valid_q;
  assign gp_fault_o = fault_q;

  p_gp_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mgmt_mode_i) |=> gp_fault_o);
  p_discard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mgmt_mode_i) |=> ($stable(base_q) && $stable(mask_q) && $stable(type_q) && $stable(valid_q)));
endmodule

// File: rtl/mrg_match.sv
module mrg_match
  import mrg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPE_W-1:0] gen_type_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_pfn_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [ADDR_W-PAGE_W-1:0] mask_pfn_i,
  input  logic              valid_i,
  output logic              hit_o,
  output logic              blocked_o,
  output logic [TYPE_W-1:0] eff_type_o
);
  logic [ADDR_W-PAGE_W-1:0] diff;

  assign diff  = (addr_i[ADDR_W-1:PAGE_W] ^ base_pfn_i) & mask_pfn_i;
  assign hit_o = valid_i && (diff == '0);

  // range overrides general cacheability on overlap
  always_comb begin
    blocked_o  = 1'b0;
    eff_type_o = gen_type_i;
    if (hit_o) begin
      if (mgmt_mode_i) begin
        eff_type_o = type_i;
      end else begin
        eff_type_o = MT_UC;
        blocked_o  = 1'b1;
      end
    end
  end

  p_no_hit_invalid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
  p_block_uc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (eff_type_o == MT_UC && !mgmt_mode_i && hit_o));
  p_mgmt_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_mode_i |-> !blocked_o);
endmodule

// File: rtl/mrg_reloc.sv
module mrg_reloc #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter logic [31:0] LAPIC_RESET = 32'hFEE0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_pfn_i,
  input  logic [ADDR_W-PAGE_W-1:0] mask_pfn_i,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] lapic_base_o,
  output logic              fault_o
);
  localparam int PFN_W = ADDR_W - PAGE_W;
  localparam logic [PFN_W-1:0] RESET_PFN = LAPIC_RESET[ADDR_W-1:PAGE_W];

  logic [PFN_W-1:0] pfn_q;
  logic             fault_q, clash;

  // window is one page, so overlap reduces to a page-number match
  assign clash = valid_i && (((wdata_i[ADDR_W-1:PAGE_W] ^ base_pfn_i) & mask_pfn_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfn_q   <= RESET_PFN;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_i && clash;
      if (wr_i && !clash) pfn_q <= wdata_i[ADDR_W-1:PAGE_W];
    end
  end

  assign lapic_base_o = {pfn_q, {PAGE_W{1'b0}}};
  assign fault_o      = fault_q;

  p_reloc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(lapic_base_o));
endmodule

// File: rtl/mgmt_range_guard.sv
module mgmt_range_guard
  import mrg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int VAR_COUNT = 10,
  parameter logic [31:0] LAPIC_RESET = 32'hFEE0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_mode_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              gp_fault_o,
  output logic [ADDR_W-1:0] cap_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic [TYPE_W-1:0] gen_type_i,
  output logic              hit_o,
  output logic              blocked_o,
  output logic [TYPE_W-1:0] eff_type_o,
  input  logic              lapic_wr_i,
  input  logic [ADDR_W-1:0] lapic_wdata_i,
  output logic [ADDR_W-1:0] lapic_base_o,
  output logic              reloc_fault_o
);
  localparam int PFN_W = ADDR_W - PAGE_W;

  logic [PFN_W-1:0]  base_pfn, mask_pfn;
  logic [TYPE_W-1:0] rng_type;
  logic              rng_valid;

  always_comb begin
    cap_o = '0;
    cap_o[CAP_RANGE_BIT] = 1'b1;
    cap_o[7:0] = 8'(VAR_COUNT);
  end

  mrg_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni, .mgmt_mode_i,
    .wr_i(reg_wr_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_pfn_o(base_pfn), .type_o(rng_type), .mask_pfn_o(mask_pfn),
    .valid_o(rng_valid), .gp_fault_o(gp_fault_o), .rdata_o(reg_rdata_o)
  );

  mrg_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_match (
    .clk_i, .rst_ni, .mgmt_mode_i,
    .addr_i(lookup_addr_i), .gen_type_i(gen_type_i),
    .base_pfn_i(base_pfn), .type_i(rng_type), .mask_pfn_i(mask_pfn),
    .valid_i(rng_valid), .hit_o(hit_o), .blocked_o(blocked_o),
    .eff_type_o(eff_type_o)
  );

  mrg_reloc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LAPIC_RESET(LAPIC_RESET)) u_reloc (
    .clk_i, .rst_ni, .wr_i(lapic_wr_i), .wdata_i(lapic_wdata_i),
    .base_pfn_i(base_pfn), .mask_pfn_i(mask_pfn), .valid_i(rng_valid),
    .lapic_base_o(lapic_base_o), .fault_o(reloc_fault_o)
  );
endmodule

// File: tb/mgmt_range_guard_tb_top.sv
module mgmt_range_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mgmt = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, cap;
  logic gp_fault, hit, blocked, lapic_wr = 1'b0, reloc_fault;
  logic [31:0] laddr = '0, lapic_wdata = '0, lapic_base;
  logic [7:0] gtype = '0, etype;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] sh_base = '0, sh_mask = '0, sh_lapic = 32'hFEE0_0000;

  always #10 clk = ~clk;

  mgmt_range_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_mode_i(mgmt),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .gp_fault_o(gp_fault), .cap_o(cap),
    .lookup_addr_i(laddr), .gen_type_i(gtype), .hit_o(hit),
    .blocked_o(blocked), .eff_type_o(etype),
    .lapic_wr_i(lapic_wr), .lapic_wdata_i(lapic_wdata),
    .lapic_base_o(lapic_base), .reloc_fault_o(reloc_fault)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [31:0] a);
    return sh_mask[11] && (((a ^ sh_base) & sh_mask & 32'hFFFF_F000) == 0);
  endfunction

  task automatic reg_write(logic sel, logic [31:0] d, logic m);
    @(negedge clk);
    mgmt = m; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R4 gp_fault", 32'(gp_fault), 32'(!m));
    if (m) begin
      if (sel) sh_mask = d & 32'hFFFF_F800;
      else     sh_base = d & 32'hFFFF_F0FF;
    end
    #1;
    chk(m ? "R3 readback" : "R4 discard", reg_rdata, sel ? sh_mask : sh_base);
    @(negedge clk);
    chk("R4 one cycle", 32'(gp_fault), 0);
  endtask

  task automatic lookup(logic [31:0] a, logic [7:0] g, logic m);
    logic h;
    @(negedge clk);
    laddr = a; gtype = g; mgmt = m;
    #2;
    h = exp_hit(a);
    chk("R5 hit", 32'(hit), 32'(h));
    if (h && !m) begin
      chk("R6 blocked", 32'(blocked), 1); chk("R6 type", 32'(etype), 0);
    end else if (h) begin
      chk("R7 blocked", 32'(blocked), 0); chk("R7 type", 32'(etype), 32'(sh_base[7:0]));
    end else begin
      chk("R8 blocked", 32'(blocked), 0); chk("R8 type", 32'(etype), 32'(g));
    end
  endtask

  task automatic reloc(logic [31:0] d, logic m);
    logic rej;
    @(negedge clk);
    lapic_wr = 1'b1; lapic_wdata = d; mgmt = m;
    rej = exp_hit(d);
    @(negedge clk);
    lapic_wr = 1'b0;
    if (!rej) sh_lapic = d & 32'hFFFF_F000;
    chk(rej ? "R10 fault" : "R9 no fault", 32'(reloc_fault), 32'(rej));
    chk(rej ? "R10 base held" : "R9 base moved", lapic_base, sh_lapic);
    @(negedge clk);
    chk("R10 one cycle", 32'(reloc_fault), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 1'b0; #1; chk("R1 base", reg_rdata, 0);
    reg_sel = 1'b1; #1; chk("R1 mask", reg_rdata, 0);
    chk("R1 lapic", lapic_base, 32'hFEE0_0000);
    chk("R1 faults", {30'd0, gp_fault, reloc_fault}, 0);
    chk("R2 cap", cap, 32'h0000_080A);
    lookup(32'h0000_0000, 8'd6, 1'b0);
    // directed: 8 MB range at 0xAB000000, write-back
    reg_write(1'b0, 32'hAB00_0F06, 1'b1);
    reg_write(1'b1, 32'hFF80_0FFF, 1'b1);
    reg_write(1'b1, 32'h0000_0000, 1'b0);  // R4 attempt to disable
    lookup(32'hAB12_3456, 8'd4, 1'b0);
    lookup(32'hAB7F_FFFF, 8'd4, 1'b1);
    lookup(32'hAB80_0000, 8'd5, 1'b0);
    lookup(32'hAAFF_FFFF, 8'd6, 1'b1);
    reloc(32'hAB00_1234, 1'b0);
    reloc(32'hAB40_0000, 1'b1);
    reloc(32'hFEF0_0ABC, 1'b0);
    // clear valid, range opens
    reg_write(1'b1, 32'hFF80_0000, 1'b1);
    lookup(32'hAB00_0000, 8'd3, 1'b0);
    reloc(32'hAB00_0000, 1'b0);
    reg_write(1'b1, 32'hFFFF_F800, 1'b1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] a;
      op = $urandom % 6;
      a = ($urandom % 2) ? ((sh_base & sh_mask) | ($urandom & ~sh_mask)) : $urandom;
      case (op)
        0: reg_write(1'b0, $urandom, 1'($urandom));
        1: reg_write(1'b1, ($urandom & 32'hFFF0_0000) | ($urandom % 8 == 0 ? 32'h0 : 32'h800) | ($urandom & 32'h7FF),
                     1'($urandom));
        2, 3: lookup(a, 8'($urandom), 1'($urandom));
        default: reloc(a, 1'($urandom));
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule